// File: doc/BRIEF.md
# Byte-wide SPI controller with completion and collision flags

This block is a byte-serial SPI engine hung on an 8-bit register bus. Software configures it through a control register, watches it through a status register and moves bytes through a data register. In controller (master) mode a data write launches an 8-bit MSB-first exchange: the block produces SCK from the system clock, shifts out on one SCK edge and samples on the other, as chosen by the clock polarity and phase bits. In target (slave) mode the external SCK, MOSI and SS are synchronized into the system clock domain and the same shift engine runs off the detected edges.

Two flags report progress. The done flag rises when a byte completes, or when SS is pulled low while the block is the controller. The collision flag rises when a data write arrives while a byte is still moving; that write is dropped. Both flags clear when software reads the status register with a flag up and then touches the data register. The done flag also clears on an interrupt acknowledge pulse. An interrupt request combines the done flag, a local enable and a global enable input.

Register map: address 0 control (bit 7 interrupt enable, bit 6 block enable, bit 4 controller mode, bit 3 CPOL, bit 2 CPHA, bits 1:0 rate; bit 5 reads zero), address 1 status, address 2 data. Reads are combinational on `rdata_o`; read side effects happen on the clock edge that samples `rd_en_i`.

Top module: `spi_port`

## Requirements
- R1: When the last of the 16 SCK edges of a byte is processed, status bit 7 (done) is set on that clock edge.
- R2: `irq_o` is high exactly when done is set, control bit 7 is set and `gie_i` is high.
- R3: In controller mode with the block enabled, a low level on `ss_ni` (after synchronization) sets done and aborts any byte in flight, returning SCK to its idle level.
- R4: A cycle with `irq_ack_i` high clears done unless done is being set in the same cycle.
- R5: A status read while done or collision is set, followed by a data-register read or write, clears both flags; a flag event in the same cycle as the clearing access wins and leaves its flag set.
- R6: A data write while a byte is in progress sets status bit 6 (collision) and does not alter the byte being sent.
- R7: Status bits 5 to 1 always read zero; status bit 0 is the double-speed bit, written through the status address and read back.
- R8: In controller mode a data write starts a transfer of that byte MSB first on `mosi_o`; a data read returns the byte received on `miso_i`.
- R9: SCK idles at CPOL; with CPHA 0 data is sampled on the leading edge and changed on the trailing edge, with CPHA 1 changed on the leading and sampled on the trailing edge.
- R10: In controller mode a byte takes 16·H system cycles from the data-write edge to done, with H = D/2 and D = 4, 16, 64, 128 for rate 0..3, halved again when double speed is set (shortest SCK period two cycles).
- R11: In target mode, with SS low, the block shifts its loaded byte out MSB first on `miso_o` and receives the byte on `mosi_i`, setting done at the end.
- R12: In target mode a rise of SS in the middle of a byte drops the partial byte without setting done; the next byte is framed from its first bit.
- R13: After reset all registers read zero, `irq_o`, `sck_o`, `mosi_o` and `miso_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 2 | Register address |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe (side effects only) |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` |
| gie_i | input | 1 | Global interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge pulse |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (target mode) |
| sck_o | output | 1 | Serial clock out (controller mode) |
| mosi_i | input | 1 | Serial data in (target mode) |
| mosi_o | output | 1 | Serial data out (controller mode) |
| miso_i | input | 1 | Serial data in (controller mode) |
| miso_o | output | 1 | Serial data out (target mode) |
| ss_ni | input | 1 | Select, active low |

## Verification
The completion of a byte and the clearing data access can land on the same clock edge, and so can a collision write and the clearing access. The bench runs a byte at the fastest rate (16 cycles), plants a collision write and a status read inside it, then times a data read to sample on exactly the edge on which the byte completes; it judges that done survives while collision is cleared. A controller sweep over all modes, rates and speeds checks cycle counts and received bytes against arithmetic on the rate table.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int BYTE_W = 8;
  localparam int HALF_W = 7;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int C_IE   = 7;
  localparam int C_EN   = 6;
  localparam int C_MST  = 4;
  localparam int C_CPOL = 3;
  localparam int C_CPHA = 2;
  localparam logic [7:0] CTRL_MASK = 8'hDF;

  // half SCK period in system cycles
  function automatic logic [HALF_W-1:0] half_cycles(logic [1:0] rate, logic dbl);
    logic [7:0] base;
    case (rate)
      2'd0:    base = 8'd4;
      2'd1:    base = 8'd16;
      2'd2:    base = 8'd64;
      default: base = 8'd128;
    endcase
    return dbl ? {1'b0, base[7:2]} : base[7:1];
  endfunction
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int         N       = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= RST_VAL;
      sync_q <= RST_VAL;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen #(
  parameter int HALF_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic              cpol_i,
  input  logic [HALF_W-1:0] half_i,
  output logic              tick_o,
  output logic              sck_o
);
  logic [HALF_W-1:0] cnt_q;
  logic              sck_q;

  assign tick_o = run_i && (cnt_q == half_i - HALF_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      sck_q <= cpol_i;
    end else if (tick_o) begin
      cnt_q <= '0;
      sck_q <= ~sck_q;
    end else begin
      cnt_q <= cnt_q + HALF_W'(1);
    end
  end

  assign sck_o = sck_q;

  a_r10_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && half_i > HALF_W'(1) && $stable(half_i)) |=> !tick_o);
endmodule

// File: rtl/spi_port_shift.sv
module spi_port_shift #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cpha_i,
  input  logic          load_i,
  input  logic          start_i,
  input  logic [DW-1:0] load_data_i,
  input  logic          edge_i,
  input  logic          abort_i,
  input  logic          sdi_i,
  output logic          sdo_o,
  output logic          run_o,
  output logic          mid_o,
  output logic          done_o,
  output logic [DW-1:0] rx_o
);
  localparam int        KW   = $clog2(2 * DW);
  localparam logic [KW-1:0] LAST = KW'(2 * DW - 1);

  logic [DW-1:0] tx_q, rx_q, buf_q;
  logic [KW-1:0] k_q;
  logic          run_q;
  logic          sample_edge, shift_edge;

  assign sample_edge = (k_q[0] == cpha_i);
  assign shift_edge  = !sample_edge && (k_q != '0);
  assign done_o      = edge_i && !abort_i && (k_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q  <= '0;
      rx_q  <= '0;
      buf_q <= '0;
      k_q   <= '0;
      run_q <= 1'b0;
    end else if (abort_i) begin
      k_q   <= '0;
      rx_q  <= '0;
      run_q <= 1'b0;
    end else if (load_i) begin
      tx_q  <= load_data_i;
      k_q   <= '0;
      run_q <= start_i;
    end else if (edge_i) begin
      if (sample_edge) rx_q <= {rx_q[DW-2:0], sdi_i};
      else if (shift_edge) tx_q <= {tx_q[DW-2:0], 1'b0};
      if (k_q == LAST) begin
        k_q   <= '0;
        run_q <= 1'b0;
        buf_q <= sample_edge ? {rx_q[DW-2:0], sdi_i} : rx_q;
      end else begin
        k_q <= k_q + KW'(1);
      end
    end
  end

  assign sdo_o = tx_q[DW-1];
  assign run_o = run_q;
  assign mid_o = (k_q != '0);
  assign rx_o  = buf_q;

  a_r12_abort_resets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> (k_q == '0 && !run_q));
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] addr_i,
  input  logic       wr_en_i,
  input  logic       rd_en_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o,
  input  logic       gie_i,
  input  logic       irq_ack_i,
  output logic       irq_o,
  input  logic       sck_i,
  output logic       sck_o,
  input  logic       mosi_i,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic       miso_o,
  input  logic       ss_ni
);
  logic [7:0] ctrl_q;
  logic       dbl_q, done_q, wcol_q, arm_q;
  logic       en, mst, cpol, cpha;
  logic [HALF_W-1:0] half;

  logic [2:0] pins_s;
  logic       sck_s, mosi_s, ss_s, sck_prev_q;
  logic       tick, sck_gen, sdo, run, mid, done_pulse;
  logic [BYTE_W-1:0] rx_byte;
  logic       busy, edge_any, abort, ss_fault;
  logic       data_wr, data_rd, data_acc, stat_rd, load;
  logic       set_done, set_wcol, clr_flags;

  assign en   = ctrl_q[C_EN];
  assign mst  = ctrl_q[C_MST];
  assign cpol = ctrl_q[C_CPOL];
  assign cpha = ctrl_q[C_CPHA];
  assign half = half_cycles(ctrl_q[1:0], dbl_q);

  spi_port_sync #(.N(3), .RST_VAL(3'b100)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ss_ni, mosi_i, sck_i}),
    .q_o   (pins_s)
  );
  assign {ss_s, mosi_s, sck_s} = pins_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sck_prev_q <= 1'b0;
    else         sck_prev_q <= sck_s;
  end

  spi_port_clkgen #(.HALF_W(HALF_W)) u_clkgen (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (run),
    .cpol_i(cpol),
    .half_i(half),
    .tick_o(tick),
    .sck_o (sck_gen)
  );

  assign busy     = mst ? run : mid;
  assign ss_fault = en && mst && !ss_s;
  assign abort    = !en || ss_fault || (!mst && ss_s && mid);
  assign edge_any = mst ? tick : (en && !ss_s && (sck_s ^ sck_prev_q));

  assign data_wr  = wr_en_i && addr_i == ADDR_DATA;
  assign data_rd  = rd_en_i && addr_i == ADDR_DATA;
  assign data_acc = data_wr || data_rd;
  assign stat_rd  = rd_en_i && addr_i == ADDR_STAT;
  assign load     = data_wr && en && !busy;

  spi_port_shift #(.DW(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cpha_i     (cpha),
    .load_i     (load),
    .start_i    (mst),
    .load_data_i(wdata_i),
    .edge_i     (edge_any),
    .abort_i    (abort),
    .sdi_i      (mst ? miso_i : mosi_s),
    .sdo_o      (sdo),
    .run_o      (run),
    .mid_o      (mid),
    .done_o     (done_pulse),
    .rx_o       (rx_byte)
  );

  assign set_done  = done_pulse || ss_fault;
  assign set_wcol  = data_wr && busy;
  assign clr_flags = data_acc && arm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      dbl_q  <= 1'b0;
      done_q <= 1'b0;
      wcol_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (wr_en_i && addr_i == ADDR_CTRL) ctrl_q <= wdata_i & CTRL_MASK;
      if (wr_en_i && addr_i == ADDR_STAT) dbl_q  <= wdata_i[0];

      if (set_done)                    done_q <= 1'b1;
      else if (clr_flags || irq_ack_i) done_q <= 1'b0;

      if (set_wcol)       wcol_q <= 1'b1;
      else if (clr_flags) wcol_q <= 1'b0;

      if (stat_rd)       arm_q <= done_q || wcol_q;
      else if (data_acc) arm_q <= 1'b0;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = ctrl_q;
      ADDR_STAT: rdata_o = {done_q, wcol_q, 5'b0, dbl_q};
      ADDR_DATA: rdata_o = rx_byte;
      default:   rdata_o = '0;
    endcase
  end

  assign irq_o  = done_q && ctrl_q[C_IE] && gie_i;
  assign sck_o  = sck_gen;
  assign mosi_o = en && mst && sdo;
  assign miso_o = en && !mst && !ss_s && sdo;

  a_r1_done_follows_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_pulse |=> done_q);
  a_r4_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_ack_i && !set_done) |=> !done_q);
  a_r6_wcol_on_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_wr && busy) |=> wcol_q);
  a_r5_clear_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_acc && arm_q && !set_done && !set_wcol) |=> (!done_q && !wcol_q));
  a_r9_idle_level: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && $past(!run) && $stable(cpol)) |-> (sck_o == cpol));
endmodule

// File: tb/spi_port_tb_top.sv
module spi_port_tb_top;
  logic       clk_i = 1'b0, rst_ni = 1'b0;
  logic [1:0] addr_i = '0;
  logic       wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wdata_i = '0, rdata_o;
  logic       gie_i = 1'b1, irq_ack_i = 1'b0, irq_o;
  logic       sck_i = 1'b0, sck_o, mosi_i = 1'b0, mosi_o;
  logic       miso_i = 1'b0, miso_o, ss_ni = 1'b1;

  int checks = 0, errors = 0;
  logic       tcpol = 1'b0, tcpha = 1'b0;
  logic [7:0] bs_pat = '0, bs_rx = '0;
  int         bs_n = 0;

  always #10 clk_i = ~clk_i;

  spi_port dut_i (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    addr_i = a; rd_en_i = 1'b1;
    #1 d = rdata_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic arm_slave(input logic [7:0] p);
    bs_pat = p; bs_rx = '0; bs_n = 0; miso_i = p[7];
  endtask

  // bench model of an external target for controller-mode runs
  always @(sck_o) begin
    #1;
    if (sck_o != tcpol) begin
      if (!tcpha) bs_rx = {bs_rx[6:0], mosi_o};
      else if (bs_n < 8) begin miso_i = bs_pat[7 - bs_n]; bs_n++; end
    end else begin
      if (tcpha) bs_rx = {bs_rx[6:0], mosi_o};
      else begin bs_n++; if (bs_n < 8) miso_i = bs_pat[7 - bs_n]; end
    end
  end

  // bench acting as controller for target-mode runs
  task automatic slv_xfer(input logic [7:0] mb, input int nbits, output logic [7:0] got);
    got = '0;
    ss_ni = 1'b0; idle(4);
    for (int i = 0; i < nbits; i++) begin
      if (!tcpha) mosi_i = mb[7 - i];
      idle(6); sck_i = ~tcpol; idle(6);
      if (tcpha) mosi_i = mb[7 - i];
      got = {got[6:0], miso_o};
      idle(6); sck_i = tcpol;
    end
    idle(6); ss_ni = 1'b1; idle(4);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] d, tx, pat, got;
    int n, h, base;
    idle(2); rst_ni = 1'b1; idle(1);

    // R13 reset state
    rd(2'd0, d); chk("R13 ctrl", d, 8'h00);
    rd(2'd1, d); chk("R13 status", d, 8'h00);
    rd(2'd2, d); chk("R13 data", d, 8'h00);
    chk("R13 pins", {irq_o, sck_o, mosi_o, miso_o}, 4'b0);

    // R7 double-speed bit and reserved bits
    wr(2'd1, 8'hFF); rd(2'd1, d); chk("R7 status readback", d, 8'h01);
    wr(2'd1, 8'h00);

    // R8 R9 R10 R1: controller sweep over mode, rate, speed
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 4; r++)
        for (int s = 0; s < 2; s++) begin
          tcpol = m[1]; tcpha = m[0];
          wr(2'd1, 8'(s));
          wr(2'd0, 8'hD0 | 8'(m << 2) | 8'(r));
          idle(2);
          chk("R9 idle level", sck_o, tcpol);
          tx  = 8'hA5 ^ 8'(m * 37 + r * 11 + s * 90);
          pat = 8'h3C ^ 8'(m * 71 + r * 5 + s * 129);
          arm_slave(pat);
          base = (r == 0) ? 4 : (r == 1) ? 16 : (r == 2) ? 64 : 128;
          h = (base / 2) >> s;
          wr(2'd2, tx);
          n = 0;
          while (n < 3000) begin
            @(posedge clk_i); n++;
            @(negedge clk_i);
            if (irq_o) break;
          end
          chk("R10 byte cycles", n, 16 * h);
          rd(2'd1, d); chk("R1 done flag", d, 8'h80 | 8'(s));
          rd(2'd2, d); chk("R8 received byte", d, pat);
          chk("R9 byte seen by target", bs_rx, tx);
          rd(2'd1, d); chk("R5 flags cleared", d, 8'(s));
          chk("R9 idle after byte", sck_o, tcpol);
        end

    // R6 collision and R5 same-cycle set versus clear (H=1, 16 cycles)
    tcpol = 1'b0; tcpha = 1'b0;
    wr(2'd1, 8'h01); wr(2'd0, 8'hD0); idle(2);
    arm_slave(8'h96);
    wr(2'd2, 8'h5A);          // edge c0
    wr(2'd2, 8'hFF);          // edge c0+1: collision
    rd(2'd1, d);              // edge c0+2: arms clear
    chk("R6 collision flag", d[6], 1'b1);
    idle(13);
    rd(2'd2, d);              // edge c0+16: byte completes here
    rd(2'd1, d);
    chk("R5 done wins over clear", d[7], 1'b1);
    chk("R5 collision cleared", d[6], 1'b0);
    chk("R6 byte unaltered", bs_rx, 8'h5A);

    // R2 interrupt gating
    gie_i = 1'b0; #1 chk("R2 global gate", irq_o, 1'b0);
    gie_i = 1'b1; #1 chk("R2 raised", irq_o, 1'b1);
    wr(2'd0, 8'h50); #1 chk("R2 local gate", irq_o, 1'b0);
    wr(2'd0, 8'hD0);
    // R4 acknowledge
    irq_ack_i = 1'b1; idle(1); irq_ack_i = 1'b0;
    rd(2'd1, d); chk("R4 ack clears done", d[7], 1'b0);
    chk("R4 irq low", irq_o, 1'b0);

    // R3 select fault in controller mode
    wr(2'd1, 8'h00); wr(2'd0, 8'hD3); idle(2);
    arm_slave(8'h00);
    wr(2'd2, 8'hC3); idle(50);
    ss_ni = 1'b0; idle(5);
    rd(2'd1, d); chk("R3 fault sets done", d[7], 1'b1);
    chk("R3 sck idle after abort", sck_o, 1'b0);
    ss_ni = 1'b1; idle(4);
    rd(2'd1, d); rd(2'd2, d);
    wr(2'd2, 8'h11);
    rd(2'd1, d); chk("R3 engine free after abort", d, 8'h00);
    n = 0;
    while (!irq_o && n < 20000) begin idle(1); n++; end
    rd(2'd1, d); rd(2'd2, d);

    // R11 target mode, two modes
    for (int m = 0; m < 4; m += 3) begin
      tcpol = m[1]; tcpha = m[0];
      sck_i = tcpol;
      wr(2'd0, 8'hC0 | 8'(m << 2)); idle(4);
      tx = 8'hB4 ^ 8'(m);
      wr(2'd2, tx);
      slv_xfer(8'h6D ^ 8'(m * 17), 8, got);
      chk("R11 target sent", got, tx);
      rd(2'd1, d); chk("R11 target done", d[7], 1'b1);
      rd(2'd2, d); chk("R11 target received", d, 8'h6D ^ 8'(m * 17));
    end

    // R12 select rise mid byte
    wr(2'd2, 8'h0F);
    slv_xfer(8'hE1, 3, got);
    rd(2'd1, d); chk("R12 no done on partial", d[7], 1'b0);
    wr(2'd2, 8'h0F);
    slv_xfer(8'h47, 8, got);
    rd(2'd1, d); chk("R12 next byte done", d[7], 1'b1);
    rd(2'd2, d); chk("R12 next byte framed", d, 8'h47);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule